// File: doc/BRIEF.md
# Paged Memory Decoder with Bus Strobes

This block is the glue logic between an 8-bit processor with a 16-bit address bus and its memory and peripheral chips. Each address maps to exactly one active-low chip select. The lower half of the map goes to RAM, except for a small window that belongs to the processor itself and one 256-byte I/O page. The upper half is cut into 4K blocks. Pairs of those blocks form 8K ROM selects, and two single blocks serve an expansion port and video memory.

The processor has a single read/write line, high for a read. The block turns it into separate active-low read and write strobes that are only live while the E clock is high.

A 2-bit page register is loaded by a processor write to address 0x0100. Its value picks which of four 32K RAM chips answers to the lower-half RAM addresses, which gives 128K of RAM in total. The register resets to page 0.

Top module: `paged_mem_decoder`

## Requirements
- R1: Addresses 0xE000–0xFFFF (including the reset vector at 0xFFFE–0xFFFF) assert only `cs_boot_n`.
- R2: Addresses 0xC000–0xDFFF assert only `cs_rom2_n`; addresses 0x8000–0x9FFF assert only `cs_xrom_n`.
- R3: Addresses 0xA000–0xAFFF assert only `cs_exp_n`; addresses 0xB000–0xBFFF assert only `cs_vid_n`.
- R4: A RAM select asserts for 0x0020–0x007F and 0x0200–0x7FFF. No select at all asserts for 0x0000–0x001F or 0x0080–0x00FF.
- R5: Addresses 0x0100–0x01FF assert only `cs_io_n`.
- R6: For a RAM address, the asserted RAM select is bit `page` of `cs_ram_n`, where `cs_ram_n[k]` belongs to RAM chip k. No other RAM bit asserts.
- R7: At most one chip select is low at any time, and all selects stay high while `vma` is low.
- R8: `rd_n` is low exactly when `e_clk` is high and `rw` is high.
- R9: `wr_n` is low exactly when `e_clk` is high and `rw` is low.
- R10: A rising `clk` edge loads `page` from `din[1:0]` when the bus shows `vma`=1, `e_clk`=1, `rw`=0 and `addr`=0x0100. Writes to other addresses, reads of 0x0100 and writes with `e_clk` low leave `page` unchanged.
- R11: After reset, `page` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the page register |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus |
| din | input | 8 | Processor data bus (write data) |
| rw | input | 1 | Read/write line, 1 = read, 0 = write |
| e_clk | input | 1 | Processor E clock (data phase when high) |
| vma | input | 1 | Valid bus access in this cycle |
| cs_ram_n | output | 4 | Active-low selects for RAM chips 0..3 |
| cs_io_n | output | 1 | Active-low external I/O select |
| cs_boot_n | output | 1 | Active-low boot ROM select |
| cs_rom2_n | output | 1 | Active-low second ROM select |
| cs_xrom_n | output | 1 | Active-low expansion ROM select |
| cs_exp_n | output | 1 | Active-low expansion block select |
| cs_vid_n | output | 1 | Active-low video RAM select |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| page | output | 2 | Current RAM page |

## Verification
The chip selects and strobes are purely combinational, so they are due in the same cycle as the address or control change. The bench sets each address or control pattern and samples one nanosecond later, without waiting for a clock edge. The page value is due one rising `clk` edge after a qualifying write. The bench drives the write at a falling edge and reads `page` back at the next falling edge. It then sweeps the full address space once per page value and checks the selects after each new page setting.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

   // Decoded address region, before page steering and bus qualification
   typedef enum logic [2:0] {
      RG_NONE = 3'd0,
      RG_RAM  = 3'd1,
      RG_IO   = 3'd2,
      RG_BOOT = 3'd3,
      RG_ROM2 = 3'd4,
      RG_XROM = 3'd5,
      RG_EXP  = 3'd6,
      RG_VID  = 3'd7
   } region_e;

   // Role of each 4K block in the upper half, indexed by the three bits below the MSB
   function automatic region_e upper_role(input logic [2:0] blk);
      case (blk)
         3'd0, 3'd1: return RG_XROM;
         3'd2:       return RG_EXP;
         3'd3:       return RG_VID;
         3'd4, 3'd5: return RG_ROM2;
         default:    return RG_BOOT;
      endcase
   endfunction

endpackage

// File: rtl/mdec_region_decode.sv
module mdec_region_decode
   import mdec_pkg::*;
#(
   parameter int   ADDR_W      = 16,
   parameter logic [7:0] IO_PAGE     = 8'h01,
   parameter logic [7:0] LOW_RAM_MIN = 8'h20,
   parameter logic [7:0] LOW_RAM_MAX = 8'h7F
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region
);
   localparam int HI_BIT  = ADDR_W - 1;
   localparam int BLK_MSB = ADDR_W - 2;
   localparam int BLK_LSB = ADDR_W - 4;
   localparam int PG_LSB  = 8;

   generate
      if (ADDR_W < 12) begin : g_bad_width
         $error("mdec_region_decode: ADDR_W must be at least 12");
      end
   endgenerate

   logic [ADDR_W-PG_LSB-1:0] pg_idx;
   logic [7:0]               pg_off;
   logic [2:0]               blk_idx;

   assign pg_idx  = addr[ADDR_W-1:PG_LSB];
   assign pg_off  = addr[PG_LSB-1:0];
   assign blk_idx = addr[BLK_MSB:BLK_LSB];

   always_comb begin
      region = RG_NONE;
      if (addr[HI_BIT]) begin
         region = upper_role(blk_idx);
      end else if (pg_idx == '0) begin
         if (pg_off >= LOW_RAM_MIN && pg_off <= LOW_RAM_MAX)
            region = RG_RAM;
      end else if (pg_idx == (ADDR_W-PG_LSB)'(IO_PAGE)) begin
         region = RG_IO;
      end else begin
         region = RG_RAM;
      end
   end

endmodule

// File: rtl/mdec_bank_select.sv
module mdec_bank_select
   import mdec_pkg::*;
#(
   parameter int PAGE_W = 2
) (
   input  region_e           region,
   input  logic              vma,
   input  logic [PAGE_W-1:0] page,
   output logic [(1<<PAGE_W)-1:0] cs_ram_n,
   output logic              cs_io_n,
   output logic              cs_boot_n,
   output logic              cs_rom2_n,
   output logic              cs_xrom_n,
   output logic              cs_exp_n,
   output logic              cs_vid_n
);
   localparam int NUM_BANKS = 1 << PAGE_W;

   logic ram_hit;
   assign ram_hit = vma && (region == RG_RAM);

   // One select per RAM chip, steered by the page value
   genvar gi;
   generate
      for (gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
         assign cs_ram_n[gi] = ~(ram_hit && (page == PAGE_W'(gi)));
      end
   endgenerate

   assign cs_io_n   = ~(vma && region == RG_IO);
   assign cs_boot_n = ~(vma && region == RG_BOOT);
   assign cs_rom2_n = ~(vma && region == RG_ROM2);
   assign cs_xrom_n = ~(vma && region == RG_XROM);
   assign cs_exp_n  = ~(vma && region == RG_EXP);
   assign cs_vid_n  = ~(vma && region == RG_VID);

endmodule

// File: rtl/mdec_strobe_gen.sv
module mdec_strobe_gen (
   input  logic rw,
   input  logic e_clk,
   output logic rd_n,
   output logic wr_n
);
   assign rd_n = ~(e_clk &  rw);
   assign wr_n = ~(e_clk & ~rw);
endmodule

// File: rtl/mdec_page_reg.sv
module mdec_page_reg #(
   parameter int   ADDR_W    = 16,
   parameter int   DATA_W    = 8,
   parameter int   PAGE_W    = 2,
   parameter logic [15:0] PAGE_ADDR = 16'h0100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              rw,
   input  logic              e_clk,
   input  logic              vma,
   output logic [PAGE_W-1:0] page
);
   generate
      if (PAGE_W > DATA_W || PAGE_W < 1) begin : g_bad_page
         $error("mdec_page_reg: PAGE_W must be 1..DATA_W");
      end
   endgenerate

   logic load;
   assign load = vma && e_clk && !rw && (addr == ADDR_W'(PAGE_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    page <= '0;
      else if (load) page <= din[PAGE_W-1:0];
   end
endmodule

// File: rtl/paged_mem_decoder.sv
module paged_mem_decoder
   import mdec_pkg::*;
#(
   parameter int   ADDR_W    = 16,
   parameter int   DATA_W    = 8,
   parameter int   PAGE_W    = 2,
   parameter logic [15:0] PAGE_ADDR = 16'h0100
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [DATA_W-1:0]       din,
   input  logic                    rw,
   input  logic                    e_clk,
   input  logic                    vma,
   output logic [(1<<PAGE_W)-1:0]  cs_ram_n,
   output logic                    cs_io_n,
   output logic                    cs_boot_n,
   output logic                    cs_rom2_n,
   output logic                    cs_xrom_n,
   output logic                    cs_exp_n,
   output logic                    cs_vid_n,
   output logic                    rd_n,
   output logic                    wr_n,
   output logic [PAGE_W-1:0]       page
);
   region_e region;

   mdec_region_decode #(.ADDR_W(ADDR_W)) u_region (
      .addr   (addr),
      .region (region)
   );

   mdec_page_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .PAGE_ADDR(PAGE_ADDR)
   ) u_page (
      .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
      .rw(rw), .e_clk(e_clk), .vma(vma), .page(page)
   );

   mdec_bank_select #(.PAGE_W(PAGE_W)) u_sel (
      .region(region), .vma(vma), .page(page),
      .cs_ram_n(cs_ram_n), .cs_io_n(cs_io_n), .cs_boot_n(cs_boot_n),
      .cs_rom2_n(cs_rom2_n), .cs_xrom_n(cs_xrom_n),
      .cs_exp_n(cs_exp_n), .cs_vid_n(cs_vid_n)
   );

   mdec_strobe_gen u_strobe (
      .rw(rw), .e_clk(e_clk), .rd_n(rd_n), .wr_n(wr_n)
   );

endmodule

// File: rtl/mdec_checker.sv
module mdec_checker #(
   parameter int   ADDR_W    = 16,
   parameter int   DATA_W    = 8,
   parameter int   PAGE_W    = 2,
   parameter logic [15:0] PAGE_ADDR = 16'h0100
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [ADDR_W-1:0]      addr,
   input logic [DATA_W-1:0]      din,
   input logic                   rw,
   input logic                   e_clk,
   input logic                   vma,
   input logic [(1<<PAGE_W)-1:0] cs_ram_n,
   input logic                   cs_io_n,
   input logic                   cs_boot_n,
   input logic                   cs_rom2_n,
   input logic                   cs_xrom_n,
   input logic                   cs_exp_n,
   input logic                   cs_vid_n,
   input logic                   rd_n,
   input logic                   wr_n,
   input logic [PAGE_W-1:0]      page
);
   localparam int NSEL = (1 << PAGE_W) + 6;

   logic [NSEL-1:0] sel_low;
   logic            pg_wr;

   assign sel_low = ~{cs_ram_n, cs_io_n, cs_boot_n, cs_rom2_n, cs_xrom_n, cs_exp_n, cs_vid_n};
   assign pg_wr   = vma && e_clk && !rw && (addr == ADDR_W'(PAGE_ADDR));

   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel_low) <= 1); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !vma |-> (sel_low == '0)); // R7
   AST_RD_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> (e_clk && rw)); // R8
   AST_WR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> (e_clk && !rw)); // R9
   AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      pg_wr |=> (page == $past(din[PAGE_W-1:0]))); // R10
   AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pg_wr |=> $stable(page)); // R10
   AST_RAM_FOLLOWS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_ram_n != '1) |-> (cs_ram_n[page] == 1'b0)); // R6
   AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      (vma && addr[ADDR_W-1:ADDR_W-3] == 3'b111) |-> !cs_boot_n); // R1

endmodule

bind paged_mem_decoder mdec_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .PAGE_ADDR(PAGE_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .rw(rw), .e_clk(e_clk),
   .vma(vma), .cs_ram_n(cs_ram_n), .cs_io_n(cs_io_n), .cs_boot_n(cs_boot_n),
   .cs_rom2_n(cs_rom2_n), .cs_xrom_n(cs_xrom_n), .cs_exp_n(cs_exp_n),
   .cs_vid_n(cs_vid_n), .rd_n(rd_n), .wr_n(wr_n), .page(page)
);

// File: tb/tb_paged_mem_decoder.sv
`timescale 1ns/1ps
module tb_paged_mem_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  din = '0;
   logic        rw = 1'b1;
   logic        e_clk = 1'b0;
   logic        vma = 1'b0;
   logic [3:0]  cs_ram_n;
   logic        cs_io_n, cs_boot_n, cs_rom2_n, cs_xrom_n, cs_exp_n, cs_vid_n;
   logic        rd_n, wr_n;
   logic [1:0]  page;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   paged_mem_decoder dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .rw(rw),
      .e_clk(e_clk), .vma(vma), .cs_ram_n(cs_ram_n), .cs_io_n(cs_io_n),
      .cs_boot_n(cs_boot_n), .cs_rom2_n(cs_rom2_n), .cs_xrom_n(cs_xrom_n),
      .cs_exp_n(cs_exp_n), .cs_vid_n(cs_vid_n), .rd_n(rd_n), .wr_n(wr_n),
      .page(page)
   );

   // Bit order: [9:6] ram3..ram0, [5] io, [4] boot, [3] rom2, [2] xrom, [1] exp, [0] vid
   function automatic logic [9:0] model_cs(input int a, input int p, input bit v);
      logic [9:0] r;
      int blk;
      r = '1;
      if (!v) return r;
      if (a >= 32768) begin
         blk = (a - 32768) / 4096;
         if (blk <= 1)      r[2] = 1'b0;
         else if (blk == 2) r[1] = 1'b0;
         else if (blk == 3) r[0] = 1'b0;
         else if (blk <= 5) r[3] = 1'b0;
         else               r[4] = 1'b0;
      end else if (a < 256) begin
         if (a >= 32 && a < 128) r[6+p] = 1'b0;
      end else if (a < 512) begin
         r[5] = 1'b0;
      end else begin
         r[6+p] = 1'b0;
      end
      return r;
   endfunction

   function automatic string req_of(input int a);
      if (a >= 57344) return "R1";
      if (a >= 49152 || a < 40960 && a >= 32768) return "R2";
      if (a >= 32768) return "R3";
      if (a >= 256 && a < 512) return "R5";
      return "R4/R6";
   endfunction

   function automatic logic [9:0] got_cs();
      return {cs_ram_n, cs_io_n, cs_boot_n, cs_rom2_n, cs_xrom_n, cs_exp_n, cs_vid_n};
   endfunction

   task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp, input string what);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Drive one bus cycle at a falling edge; page result sampled at the next falling edge
   task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input logic r, input logic e);
      @(negedge clk);
      addr = a; din = d; rw = r; e_clk = e; vma = 1'b1;
      @(negedge clk);
      vma = 1'b0; e_clk = 1'b0; rw = 1'b1;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000 && !finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected<190000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      check(page == 2'd0, "R11", 16'(page), 16'd0, "page during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(page == 2'd0, "R11", 16'(page), 16'd0, "page after reset");
      check(got_cs() == 10'h3FF, "R7", 16'(got_cs()), 16'h3FF, "selects idle after reset");

      // R8 / R9: all strobe combinations
      for (int k = 0; k < 4; k++) begin
         e_clk = k[1]; rw = k[0];
         #1;
         check(rd_n == !(k[1] && k[0]), "R8", 16'(rd_n), 16'(!(k[1] && k[0])), "read strobe");
         check(wr_n == !(k[1] && !k[0]), "R9", 16'(wr_n), 16'(!(k[1] && !k[0])), "write strobe");
      end
      e_clk = 1'b0; rw = 1'b1;

      for (int p = 0; p < 4; p++) begin
         // R10: loading page, upper data bits ignored
         bus_cycle(16'h0100, 8'(p | 8'hFC), 1'b0, 1'b1);
         check(page == 2'(p), "R10", 16'(page), 16'(p), "page load");
         // R10: ignored accesses
         bus_cycle(16'h0101, 8'(3 - p), 1'b0, 1'b1);
         check(page == 2'(p), "R10", 16'(page), 16'(p), "write to other I/O address");
         bus_cycle(16'h0100, 8'(3 - p), 1'b1, 1'b1);
         check(page == 2'(p), "R10", 16'(page), 16'(p), "read of page address");
         bus_cycle(16'h0100, 8'(3 - p), 1'b0, 1'b0);
         check(page == 2'(p), "R10", 16'(page), 16'(p), "write with E low");

         // Full address sweep with this page value
         rw = 1'b1; e_clk = 1'b0; vma = 1'b1;
         for (int a = 0; a < 65536; a++) begin
            addr = 16'(a);
            #1;
            check(got_cs() == model_cs(a, p, 1'b1), req_of(a), 16'(got_cs()),
                  16'(model_cs(a, p, 1'b1)), $sformatf("selects at %h page %0d", a, p));
         end
         // R7: no select without a valid access
         vma = 1'b0;
         for (int a = 0; a < 65536; a += 256) begin
            addr = 16'(a + 48);
            #1;
            check(got_cs() == 10'h3FF, "R7", 16'(got_cs()), 16'h3FF, "selects with vma low");
         end
      end

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule